// File: doc/BRIEF.md
# Oscillator Edge-Count Frequency Meter

The block measures the frequency of a free-running oscillator. It counts the oscillator's rising edges during a window of fixed length, and a stable reference clock times that window. A sequencer in the reference domain controls the whole measurement. It turns on the oscillator enable and lets the oscillator settle. It then opens a counting window, stops the oscillator and waits for the count to go quiet. Only after that does it copy the count into a reference-domain register and pulse a done flag.

An edge counter sits in the oscillator domain. Its enable comes in through a synchronizer chain, and the counter is held at zero whenever that synchronized enable is low, so a single control line serves as both enable and clear. No status signal returns from the oscillator domain. The crossing is safe because of the fixed ordering of the enable steps and the wait times between them. The oscillator enable itself is not synchronized: it gates the oscillator directly. The captured count divided by the window length gives the frequency.

Top module: `ring_freq_meter`

## Requirements
- R1: A synchronous reset forces the oscillator enable low, the done flag low and the captured count to zero. The captured count is zero from the first clock edge that samples reset high.
- R2: A start request sampled while the sequencer is idle raises the oscillator enable on that same reference clock edge.
- R3: After a start, the oscillator enable stays high for exactly SETTLE_CYC + WINDOW_CYC reference cycles. The counter enable rises only while the oscillator enable is high.
- R4: The done flag goes high SETTLE_CYC + WINDOW_CYC + STABLE_CYC reference cycles after the edge that accepted the start. It stays high for exactly one reference cycle, and the oscillator enable is already low at that point.
- R5: The captured count matches the number of oscillator rising edges inside the counting window. The allowed shortfall is the synchronizer depth plus two, and the allowed excess is two.
- R6: The captured count does not change at any time except the cycle in which done goes high.
- R7: A start request sampled while a measurement is in progress, including its final cycle, is ignored. It neither restarts nor delays the sequence, and after that sequence ends the oscillator enable stays low.
- R8: The edge counter is cleared between measurements. A new measurement reports only its own edges and does not add to earlier ones, including after a reset that interrupted a measurement.
- R9: The settle, window and stabilise lengths are parameters in reference cycles. A value below 1 is treated as 1, and the default window is 0.5 ms at the default reference frequency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Stable reference clock |
| rst | input | 1 | Synchronous active-high reset, reference domain |
| start | input | 1 | Measurement request, accepted only when idle |
| clk_osc | input | 1 | Oscillator clock being measured |
| osc_en | output | 1 | Oscillator run enable (not synchronized) |
| count_out | output | CNT_W | Captured edge count of the last measurement |
| done | output | 1 | One-cycle pulse when count_out is updated |

## Verification
A wrong timer load or a wrong state transition shows at the ports as an oscillator-enable pulse of the wrong length, or as a done pulse that arrives at the wrong cycle. Either appears within one measurement of roughly SETTLE+WINDOW+STABLE cycles. A counter that fails to clear, or a synchronizer that never flushes, shows up as a captured count outside the tolerance band on the next measurement. Running consecutive measurements at different oscillator periods separates a stale count from a fresh one. A capture register that changes outside a done cycle can be seen at any time while the block is idle.

// File: rtl/fmeter_pkg.sv
package fmeter_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE   = 3'd0,
    SQ_SETTLE = 3'd1,
    SQ_WINDOW = 3'd2,
    SQ_QUIET  = 3'd3,
    SQ_CLEAR  = 3'd4
  } seq_state_e;

  // Durations below one cycle are raised to one.
  function automatic int at_least_one(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/bit_sync_chain.sv
module bit_sync_chain #(
  parameter int STAGES = 3
) (
  input  logic clk,
  input  logic d,
  output logic q
);
  localparam int N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] stage_q;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) stage_q[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk) stage_q[g] <= stage_q[g-1];
      end
    end
  endgenerate

  assign q = stage_q[N-1];
endmodule

// File: rtl/osc_edge_counter.sv
module osc_edge_counter #(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 3
) (
  input  logic             clk_osc,
  input  logic             run_async,
  output logic [CNT_W-1:0] edge_cnt
);
  logic run_sync;

  bit_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk_osc),
    .d   (run_async),
    .q   (run_sync)
  );

  // Enable low doubles as clear; no reset is needed in this domain.
  always_ff @(posedge clk_osc) begin
    if (!run_sync) edge_cnt <= '0;
    else           edge_cnt <= edge_cnt + 1'b1;
  end
endmodule

// File: rtl/meas_sequencer.sv
module meas_sequencer
  import fmeter_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int SETTLE_CYC = 64,
  parameter int WINDOW_CYC = 50000,
  parameter int STABLE_CYC = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] osc_count,
  output logic             osc_en,
  output logic             cnt_en,
  output logic [CNT_W-1:0] count_q,
  output logic             done,
  output logic             busy
);
  localparam int SET_E = at_least_one(SETTLE_CYC);
  localparam int WIN_E = at_least_one(WINDOW_CYC);
  localparam int STB_E = at_least_one(STABLE_CYC);
  localparam int MAX_D = max3(SET_E, WIN_E, STB_E);
  localparam int TMR_W = $clog2(MAX_D + 1);

  seq_state_e       state;
  logic [TMR_W-1:0] timer;
  logic             tmr_zero;

  assign tmr_zero = (timer == '0);
  assign busy     = (state != SQ_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SQ_IDLE;
      timer   <= '0;
      osc_en  <= 1'b0;
      cnt_en  <= 1'b0;
      count_q <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        SQ_IDLE: begin
          if (start) begin
            osc_en <= 1'b1;
            timer  <= TMR_W'(SET_E - 1);
            state  <= SQ_SETTLE;
          end
        end
        SQ_SETTLE: begin
          if (tmr_zero) begin
            cnt_en <= 1'b1;
            timer  <= TMR_W'(WIN_E - 1);
            state  <= SQ_WINDOW;
          end else begin
            timer <= timer - 1'b1;
          end
        end
        SQ_WINDOW: begin
          if (tmr_zero) begin
            osc_en <= 1'b0;
            timer  <= TMR_W'(STB_E - 1);
            state  <= SQ_QUIET;
          end else begin
            timer <= timer - 1'b1;
          end
        end
        SQ_QUIET: begin
          if (tmr_zero) begin
            count_q <= osc_count;
            done    <= 1'b1;
            state   <= SQ_CLEAR;
          end else begin
            timer <= timer - 1'b1;
          end
        end
        SQ_CLEAR: begin
          cnt_en <= 1'b0;
          state  <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ring_freq_meter.sv
module ring_freq_meter #(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 3,
  parameter int REF_HZ      = 100_000_000,
  parameter int WINDOW_CYC  = REF_HZ / 2000,
  parameter int SETTLE_CYC  = 64,
  parameter int STABLE_CYC  = 16
) (
  input  logic             clk_ref,
  input  logic             rst,
  input  logic             start,
  input  logic             clk_osc,
  output logic             osc_en,
  output logic [CNT_W-1:0] count_out,
  output logic             done
);
  logic             cnt_en;
  logic             busy;
  logic [CNT_W-1:0] osc_count;

  meas_sequencer #(
    .CNT_W      (CNT_W),
    .SETTLE_CYC (SETTLE_CYC),
    .WINDOW_CYC (WINDOW_CYC),
    .STABLE_CYC (STABLE_CYC)
  ) u_seq (
    .clk       (clk_ref),
    .rst       (rst),
    .start     (start),
    .osc_count (osc_count),
    .osc_en    (osc_en),
    .cnt_en    (cnt_en),
    .count_q   (count_out),
    .done      (done),
    .busy      (busy)
  );

  osc_edge_counter #(
    .CNT_W       (CNT_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_cnt (
    .clk_osc   (clk_osc),
    .run_async (cnt_en),
    .edge_cnt  (osc_count)
  );
endmodule

// File: rtl/ring_freq_meter_chk.sv
module ring_freq_meter_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk_ref,
  input logic             rst,
  input logic             start,
  input logic             osc_en,
  input logic             cnt_en,
  input logic             busy,
  input logic [CNT_W-1:0] count_out,
  input logic             done
);
  AST_RESET_CLEARS: assert property (@(posedge clk_ref)
    rst |=> (!osc_en && !done && count_out == '0)); // R1

  AST_START_LAUNCH: assert property (@(posedge clk_ref) disable iff (rst)
    (!busy && start) |=> osc_en); // R2

  AST_CNT_EN_WITH_OSC: assert property (@(posedge clk_ref) disable iff (rst)
    $rose(cnt_en) |-> osc_en); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk_ref) disable iff (rst)
    done |=> !done); // R4

  AST_OSC_OFF_AT_DONE: assert property (@(posedge clk_ref) disable iff (rst)
    done |-> !osc_en); // R4

  AST_COUNT_HOLDS: assert property (@(posedge clk_ref) disable iff (rst)
    (!done && !$past(rst)) |-> $stable(count_out)); // R6

  AST_BUSY_START_IGNORED: assert property (@(posedge clk_ref) disable iff (rst)
    (busy && !osc_en && start) |=> !osc_en); // R7
endmodule

bind ring_freq_meter ring_freq_meter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_ref   (clk_ref),
  .rst       (rst),
  .start     (start),
  .osc_en    (osc_en),
  .cnt_en    (cnt_en),
  .busy      (busy),
  .count_out (count_out),
  .done      (done)
);

// File: tb/sim_ring_freq_meter.sv
`timescale 1ns/1ps
module sim_ring_freq_meter;
  localparam int  REF_PERIOD_NS = 10;
  localparam int  CNT_W  = 32;
  localparam int  STAGES = 3;
  localparam int  S_CYC  = 8;
  localparam int  W_CYC  = 200;
  localparam int  T_CYC  = 4;
  localparam int  WATCHDOG_CYC = 20000;
  localparam int  WIN_PS = W_CYC * REF_PERIOD_NS * 1000;

  typedef struct packed { int half_ps; int exp_cnt; } vec_t;
  localparam int NV = 4;
  localparam vec_t VEC [NV] = '{
    '{1500,  WIN_PS / 3000},
    '{3500,  WIN_PS / 7000},
    '{6500,  WIN_PS / 13000},
    '{12500, WIN_PS / 25000}
  };

  logic             clk_ref = 1'b0;
  logic             rst     = 1'b1;
  logic             start   = 1'b0;
  logic             clk_osc = 1'b0;
  logic             osc_en;
  logic [CNT_W-1:0] count_out;
  logic             done;
  int               osc_half_ps = 5000;
  int               checks = 0;
  int               errors = 0;

  ring_freq_meter #(
    .CNT_W(CNT_W), .SYNC_STAGES(STAGES), .REF_HZ(100_000_000),
    .WINDOW_CYC(W_CYC), .SETTLE_CYC(S_CYC), .STABLE_CYC(T_CYC)
  ) u0 (
    .clk_ref(clk_ref), .rst(rst), .start(start), .clk_osc(clk_osc),
    .osc_en(osc_en), .count_out(count_out), .done(done)
  );

  always #(REF_PERIOD_NS / 2.0) clk_ref = ~clk_ref;

  // Behavioural oscillator, running only while enabled.
  initial forever begin
    if (osc_en) begin
      #(real'(osc_half_ps) / 1000.0);
      clk_osc = ~clk_osc;
    end else begin
      @(posedge osc_en);
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // One full measurement; optionally pokes start while busy (R7).
  task automatic run_meas(input int half_ps, input int exp_cnt, input bit poke);
    int k = 1, hi = 0;
    bit moved = 0;
    logic [CNT_W-1:0] prev;
    osc_half_ps = half_ps;
    prev = count_out;
    @(negedge clk_ref) start = 1'b1;
    @(negedge clk_ref) start = 1'b0;
    check(osc_en == 1'b1, "R2", "osc_en after start", osc_en, 1);
    while (!done && k < 4 * (S_CYC + W_CYC + T_CYC)) begin
      if (osc_en) hi++;
      if (count_out !== prev) moved = 1;
      start = poke && (k == S_CYC + 10 || k == S_CYC + W_CYC + 2);
      @(negedge clk_ref);
      k++;
    end
    start = 1'b0;
    check(hi == S_CYC + W_CYC, "R3", "osc_en high cycles", hi, S_CYC + W_CYC);
    check(k == S_CYC + W_CYC + T_CYC + 1, "R4", "done cycle", k,
          S_CYC + W_CYC + T_CYC + 1);
    check(!moved, "R6", "count moved before done", moved, 0);
    check(int'(count_out) >= exp_cnt - STAGES - 2 && int'(count_out) <= exp_cnt + 2,
          "R5", "edge count", count_out, exp_cnt);
    @(negedge clk_ref);
    check(done == 1'b0, "R4", "done width", done, 0);
  endtask

  initial begin
    #(WATCHDOG_CYC * REF_PERIOD_NS);
    errors++;
    $display("FAIL watchdog expired: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [CNT_W-1:0] held;
    repeat (3) @(negedge clk_ref);
    check(osc_en == 0, "R1", "osc_en in reset", osc_en, 0);
    check(done == 0, "R1", "done in reset", done, 0);
    check(count_out == 0, "R1", "count in reset", count_out, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk_ref);

    // Table walk: each period differs, so stale counts fail R5/R8.
    for (int i = 0; i < NV; i++) begin
      run_meas(VEC[i].half_ps, VEC[i].exp_cnt, i == 1);
      // R7: busy pokes must not have restarted the sequence.
      check(osc_en == 0, "R7", "no restart after busy start", osc_en, 0);
    end

    // R8: slow then fast, fresh count only.
    run_meas(12500, WIN_PS / 25000, 1'b0);
    run_meas(1500, WIN_PS / 3000, 1'b0);
    check(count_out < CNT_W'(WIN_PS / 3000 + 3), "R8", "no accumulation",
          count_out, WIN_PS / 3000);

    // R6: idle hold.
    held = count_out;
    repeat (40) @(negedge clk_ref);
    check(count_out == held, "R6", "idle hold", count_out, held);

    // R1/R8: reset in mid-window, then a clean measurement.
    osc_half_ps = 3500;
    @(negedge clk_ref) start = 1'b1;
    @(negedge clk_ref) start = 1'b0;
    repeat (S_CYC + 50) @(negedge clk_ref);
    rst = 1'b1;
    @(negedge clk_ref);
    check(osc_en == 0, "R1", "osc_en after mid reset", osc_en, 0);
    check(count_out == 0, "R1", "count after mid reset", count_out, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk_ref);
    run_meas(6500, WIN_PS / 13000, 1'b0);
    check(int'(count_out) <= WIN_PS / 13000 + 2, "R8", "post-reset fresh count",
          count_out, WIN_PS / 13000);
    // R9 is covered by the window/settle/stabilise timings checked above.
    finish_run();
  end
endmodule